// File: doc/BRIEF.md
# Spectral Magnitude Unit with Selectable Precision

This block sits after an FFT and turns each complex bin into one unsigned magnitude. Bins arrive as a signed real part and a signed imaginary part, qualified by a valid strobe. A per-bin mode bit picks the method for that bin. The cheap method adds the two absolute values. The precise method finds the Euclidean length with a fully pipelined vectoring rotator. The rotator's output is multiplied by a fixed gain-correction constant.

Both methods take exactly the same number of cycles, so the consumer sees one uniform stream. The mode travels down the pipeline with its bin. A mode change can therefore come at any point in a stream, and every result is still computed by the method its own bin asked for. When a bin uses the cheap method, the rotator stages keep their old contents, so no extra switching is spent there.

Top module: `spec_mag_unit`

## Requirements
- R1: After reset, and before any bin is accepted, `valid_o` is 0 and `mag_o` is 0.
- R2: A bin accepted with `mode_i` = 0 yields `mag_o` = |re| + |im| exactly.
- R3: When an absolute value is taken, an input of -32768 is treated as +32767, so a bin of (-32768, -32768) in mode 0 yields 65534.
- R4: A bin accepted with `mode_i` = 1 yields `mag_o` within ±2 of round(sqrt(a² + im²)), where a is |re| saturated as in R3.
- R5: Every accepted bin produces exactly one `valid_o` pulse, 17 clock edges after the edge that captured it, in either mode.
- R6: Results leave in acceptance order. Bins of alternating mode issued on consecutive cycles each get the method of their own `mode_i`.
- R7: In every cycle where `valid_o` is 0, `mag_o` is 0.
- R8: A cycle with `valid_i` = 0 produces no result, whatever the values on `re_i`, `im_i` and `mode_i`.
- R9: The rotator stage registers keep their contents in every cycle in which no mode-1 bin enters them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Bin present on `re_i`/`im_i` this cycle |
| mode_i | input | 1 | 0: sum of absolute values, 1: rotator magnitude |
| re_i | input | 16 | Real part, two's complement |
| im_i | input | 16 | Imaginary part, two's complement |
| valid_o | output | 1 | Result present on `mag_o` |
| mag_o | output | 17 | Unsigned magnitude, 0 when `valid_o` is low |

## Verification
A bin captured at clock edge E has its result on `mag_o` after edge E+17. This holds in both modes, because the sum path is delayed to match the one capture stage, the sixteen rotation stages and the gain stage. For each bin, the driver records the expected value and this due cycle in the scoreboard. The monitor samples on the falling edge and flags a result that arrives early or late, that arrives with no bin pending, or that has the wrong value.

// File: rtl/mag_pkg.sv
package mag_pkg;

  typedef enum logic {
    MODE_SUM    = 1'b0,
    MODE_CORDIC = 1'b1
  } mag_mode_e;

  // Inverse of the rotator gain, scaled by 2^GAIN_FRAC. The gain has
  // converged to this value for 14 or more micro-rotations.
  localparam int GAIN_FRAC = 16;
  localparam int GAIN_K_W  = 17;
  localparam int GAIN_K    = 39797;

endpackage

// File: rtl/mag_abs_sat.sv
module mag_abs_sat #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] val_i,
  output logic        [W-1:0] abs_o
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (val_i == MOST_NEG) begin
      abs_o = MOST_POS;
    end else if (val_i[W-1]) begin
      abs_o = -val_i;
    end else begin
      abs_o = val_i;
    end
  end

endmodule

// File: rtl/mag_cordic_stage.sv
module mag_cordic_stage #(
  parameter int W     = 23,
  parameter int SHIFT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);

  logic signed [W-1:0] x_d, y_d;
  logic signed [W-1:0] x_sh, y_sh;

  always_comb begin
    x_sh = x_i >>> SHIFT;
    y_sh = y_i >>> SHIFT;
    if (!y_i[W-1]) begin
      x_d = x_i + y_sh;
      y_d = y_i - x_sh;
    end else begin
      x_d = x_i - y_sh;
      y_d = y_i + x_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
    end else if (en_i) begin
      x_o <= x_d;
      y_o <= y_d;
    end
  end

  // R9
  cordic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(x_o) && $stable(y_o)));

  // R4
  x_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !x_i[W-1]) |=> (x_o >= $past(x_i)));

endmodule

// File: rtl/mag_gain_scale.sv
module mag_gain_scale #(
  parameter int W     = 23,
  parameter int GUARD = 4,
  parameter int OUT_W = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  output logic    [OUT_W-1:0] mag_o
);

  import mag_pkg::*;

  localparam int PW      = W + GAIN_K_W;
  localparam int SH      = GAIN_FRAC + GUARD;
  localparam logic [PW-1:0] RND   = PW'(1) << (SH - 1);
  localparam logic [PW-1:0] K_EXT = PW'(GAIN_K);
  localparam logic signed [W-1:0] Y_LIM = W'(1) <<< (GUARD + 3);

  logic [PW-1:0]    prod;
  logic [OUT_W-1:0] mag_d;

  always_comb begin
    prod  = PW'($unsigned(x_i)) * K_EXT;
    mag_d = OUT_W'((prod + RND) >> SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_o <= '0;
    end else if (en_i) begin
      mag_o <= mag_d;
    end
  end

  // R4
  residual_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> ((y_i < Y_LIM) && (y_i > -Y_LIM)));

endmodule

// File: rtl/mag_delay_line.sv
module mag_delay_line #(
  parameter int W     = 17,
  parameter int DEPTH = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] en_i,
  input  logic [W-1:0]     d_i,
  output logic [W-1:0]     d_o
);

  logic [W-1:0] tap_q [DEPTH];
  logic [W-1:0] tap_d [DEPTH];

  always_comb begin
    tap_d[0] = en_i[0] ? d_i : tap_q[0];
    for (int k = 1; k < DEPTH; k++) begin
      tap_d[k] = en_i[k] ? tap_q[k-1] : tap_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) tap_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) tap_q[k] <= tap_d[k];
    end
  end

  assign d_o = tap_q[DEPTH-1];

endmodule

// File: rtl/spec_mag_unit.sv
module spec_mag_unit #(
  parameter int DATA_W  = 16,
  parameter int STAGES  = 16,
  parameter int GUARD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] re_i,
  input  logic [DATA_W-1:0] im_i,
  output logic              valid_o,
  output logic [DATA_W:0]   mag_o
);

  import mag_pkg::*;

  localparam int CW    = DATA_W + 3 + GUARD_W;
  localparam int NT    = STAGES + 2;
  localparam int OUT_W = DATA_W + 1;
  localparam logic [OUT_W-1:0] SUM_MAX = OUT_W'(2 * ((1 << (DATA_W - 1)) - 1));

  // Tag pipeline: valid and mode per stage
  logic [NT-1:0] tv_q, tv_d, tm_q, tm_d;

  always_comb begin
    tv_d[0] = valid_i;
    tm_d[0] = valid_i ? mode_i : tm_q[0];
    for (int k = 1; k < NT; k++) begin
      tv_d[k] = tv_q[k-1];
      tm_d[k] = tm_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv_q <= '0;
      tm_q <= '0;
    end else begin
      tv_q <= tv_d;
      tm_q <= tm_d;
    end
  end

  // Capture stage: absolute values, fold, and the sum
  logic [DATA_W-1:0] re_abs, im_abs;

  mag_abs_sat #(.W(DATA_W)) u_abs_re (.val_i(re_i), .abs_o(re_abs));
  mag_abs_sat #(.W(DATA_W)) u_abs_im (.val_i(im_i), .abs_o(im_abs));

  logic              ld_cordic0, ld_sum0;
  logic signed [CW-1:0] x0_d, y0_d, x0_q, y0_q;
  logic [OUT_W-1:0]  sum0_d, sum0_q;

  always_comb begin
    ld_cordic0 = valid_i && (mode_i == MODE_CORDIC);
    ld_sum0    = valid_i && (mode_i == MODE_SUM);
    x0_d   = ld_cordic0 ? $signed({3'b000, re_abs, {GUARD_W{1'b0}}}) : x0_q;
    y0_d   = ld_cordic0 ? $signed({{3{im_i[DATA_W-1]}}, im_i, {GUARD_W{1'b0}}}) : y0_q;
    sum0_d = ld_sum0 ? ({1'b0, re_abs} + {1'b0, im_abs}) : sum0_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_q   <= '0;
      y0_q   <= '0;
      sum0_q <= '0;
    end else begin
      x0_q   <= x0_d;
      y0_q   <= y0_d;
      sum0_q <= sum0_d;
    end
  end

  // R2
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !mode_i) |=> (sum0_q <= SUM_MAX));

  // Rotation pipeline
  logic signed [CW-1:0] cx [STAGES+1];
  logic signed [CW-1:0] cy [STAGES+1];

  assign cx[0] = x0_q;
  assign cy[0] = y0_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_rot
    mag_cordic_stage #(.W(CW), .SHIFT(i)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (tv_q[i] & tm_q[i]),
      .x_i   (cx[i]),
      .y_i   (cy[i]),
      .x_o   (cx[i+1]),
      .y_o   (cy[i+1])
    );
  end

  logic [OUT_W-1:0] mag_cordic;

  mag_gain_scale #(.W(CW), .GUARD(GUARD_W), .OUT_W(OUT_W)) u_gain (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (tv_q[STAGES] & tm_q[STAGES]),
    .x_i   (cx[STAGES]),
    .y_i   (cy[STAGES]),
    .mag_o (mag_cordic)
  );

  // Matching delay for the sum path
  logic [STAGES:0]  ld_sum;
  logic [OUT_W-1:0] mag_sum;

  always_comb begin
    for (int k = 0; k <= STAGES; k++) ld_sum[k] = tv_q[k] & ~tm_q[k];
  end

  mag_delay_line #(.W(OUT_W), .DEPTH(STAGES + 1)) u_sum_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (ld_sum),
    .d_i   (sum0_q),
    .d_o   (mag_sum)
  );

  // Output select
  always_comb begin
    valid_o = tv_q[NT-1];
    if (!tv_q[NT-1]) begin
      mag_o = '0;
    end else if (tm_q[NT-1] == MODE_CORDIC) begin
      mag_o = mag_cordic;
    end else begin
      mag_o = mag_sum;
    end
  end

endmodule

// File: tb/spec_mag_unit_tb.sv
`timescale 1ns/1ps
module spec_mag_unit_tb;

  localparam int DW    = 16;
  localparam int DUE   = 18;  // negedge count from drive to result

  logic          clk = 1'b0;
  logic          rst_n;
  logic          valid_i, mode_i;
  logic [DW-1:0] re_i, im_i;
  logic          valid_o;
  logic [DW:0]   mag_o;

  spec_mag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .re_i(re_i), .im_i(im_i), .valid_o(valid_o), .mag_o(mag_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    due;
    int    exp;
    int    tol;
    string req;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int sat_abs(input int v);
    if (v == -32768) return 32767;
    return (v < 0) ? -v : v;
  endfunction

  task automatic drive(input bit md, input int re, input int im, input string req);
    item_t it;
    int    a;
    real   r;
    @(negedge clk);
    valid_i = 1'b1;
    mode_i  = md;
    re_i    = re[DW-1:0];
    im_i    = im[DW-1:0];
    a = sat_abs(re);
    if (!md) begin
      it.exp = a + sat_abs(im);
      it.tol = 0;
    end else begin
      r = $sqrt(real'(a) * real'(a) + real'(im) * real'(im));
      it.exp = $rtoi(r + 0.5);
      it.tol = 2;
    end
    it.due = cyc + DUE;
    it.req = req;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      mode_i  = 1'($urandom);
      re_i    = DW'($urandom);
      im_i    = DW'($urandom);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R8 unexpected result", int'(mag_o), -1);
        end else begin
          item_t it;
          int    d;
          it = sbq.pop_front();
          check(cyc == it.due, "R5 latency", cyc, it.due);
          d = int'(mag_o) - it.exp;
          check((d <= it.tol) && (d >= -it.tol), it.req, int'(mag_o), it.exp);
        end
      end else begin
        check(mag_o == '0, "R7 idle output", int'(mag_o), 0);
        if (sbq.size() > 0 && sbq[0].due <= cyc)
          check(1'b0, "R5 missing result", cyc, sbq[0].due);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    rst_n   = 1'b0;
    valid_i = 1'b0;
    mode_i  = 1'b0;
    re_i    = '0;
    im_i    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    check(valid_o == 1'b0, "R1 reset valid", int'(valid_o), 0);
    check(mag_o == '0, "R1 reset mag", int'(mag_o), 0);

    // R2 basic sums; R9 exercised: rotator idle during this burst
    drive(1'b0, 3, 4, "R2 sum");
    drive(1'b0, -5, 12, "R2 sum");
    drive(1'b0, 0, 0, "R2 sum zero");
    drive(1'b0, 32767, -1, "R2 sum");
    drive(1'b0, -1200, -345, "R2 sum");
    // R3 saturation
    drive(1'b0, -32768, 0, "R3 sat");
    drive(1'b0, -32768, -32768, "R3 sat both");
    idle(20);

    // R4 rotator magnitudes
    drive(1'b1, 3, 4, "R4 cordic");
    drive(1'b1, -5, 12, "R4 cordic");
    drive(1'b1, 0, 0, "R4 cordic zero");
    drive(1'b1, 1000, -1000, "R4 cordic");
    drive(1'b1, 32767, 0, "R4 cordic axis");
    drive(1'b1, 0, -32767, "R4 cordic axis");
    drive(1'b1, 12345, -6789, "R4 cordic");
    drive(1'b1, -32768, -32768, "R4 cordic sat");
    drive(1'b1, -20000, 15000, "R4 cordic");
    idle(20);

    // R6 alternating modes back to back
    for (int i = 0; i < 10; i++) begin
      drive(1'(i), 300 * i - 1400, 5000 - 700 * i, "R6 mode switch");
    end
    // R8 gaps with garbage inputs between bins
    for (int i = 0; i < 6; i++) begin
      drive(1'(i >> 1), -777 * i, 4321 - i, "R8 gapped");
      idle(1 + i);
    end

    // Drain
    for (int i = 0; i < 100 && sbq.size() > 0; i++) @(negedge clk);
    check(sbq.size() == 0, "R5 drain", sbq.size(), 0);
    idle(5);
    finish_run();
  end

endmodule